// File: doc/BRIEF.md
# Tangential Octant Coil-Drive Mapper

This block turns a 10-bit pointer angle code into signed drive levels for the two coils of a quadrature air-core movement. The full circle is split into eight 45-degree octants. In each octant one coil is held at full magnitude and the other follows a linear ramp across the octant, which approximates a tangent law. The block produces a sign bit and an unsigned magnitude for each coil. A digital-to-analog stage further down the chain scales these values to coil voltages.

The angle code comes in on a valid/ready stream port. The block has no internal storage that can fill up, so `in_ready` is held high and it never pushes back. A word is accepted in every cycle in which `in_valid` is high. The mapped drive appears on the registered outputs one clock later, and `out_valid` is high for that one cycle. The output side has no ready input, so a consumer cannot stall it. The drive values then stay fixed until the next word is accepted.

Top module: `tan_coil_mapper`

## Requirements
- R1: Input bits 9..7 give the octant k (0..7), which covers angles from 45k to 45(k+1) degrees. Input bits 6..0 give the step n (0..127) within that octant.
- R2: For every accepted code, exactly one coil magnitude is full scale, which is 256. The other coil's magnitude is below 256.
- R3: A rising ramp has magnitude 2n+1 and a falling ramp has magnitude 255-2n. Every step therefore sits half a step into its interval, so no code ever gives a magnitude of 0.
- R4: In octants 0 and 4 the sine coil ramps up. In octants 3 and 7 the sine coil ramps down. In octants 2 and 6 the cosine coil ramps up. In octants 1 and 5 the cosine coil ramps down. In each case the other coil is at full scale.
- R5: A sign bit of 1 means negative drive. The sine sign is 1 in octants 4-7. The cosine sign is 1 in octants 2-5.
- R6: `in_ready` is always 1. A word is accepted on each clock edge where `in_valid` is 1. Its mapped outputs appear after that edge, and `out_valid` is 1 for exactly the cycle that follows an accept.
- R7: While `in_valid` is 0, the sign and magnitude outputs keep their values, whatever is on `in_code`.
- R8: After reset the outputs show the mapping of code 0: sine positive with magnitude 1, cosine positive with magnitude 256. `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Angle code valid |
| in_ready | output | 1 | Always 1; the block never pushes back |
| in_code | input | 10 | Angle code: octant in bits 9..7, step in bits 6..0 |
| out_valid | output | 1 | One-cycle pulse after each accepted code |
| sin_neg | output | 1 | Sine coil drive is negative |
| sin_mag | output | 9 | Sine coil magnitude, 0..256 |
| cos_neg | output | 1 | Cosine coil drive is negative |
| cos_mag | output | 9 | Cosine coil magnitude, 0..256 |

## Verification
The assertions check properties that can be judged in every cycle. Exactly one coil must be at full scale, and a non-full magnitude must be odd. The signs must follow the high octant bits of the word accepted one cycle before. The `out_valid` pulse and the holding of outputs between accepts are also checked every cycle. Only the bench scenarios can show that each octant picks the correct ramping coil and ramp direction, and that the ramp values are exact at both ends of an octant and in its middle. The same applies to the reset values and to back-to-back accepts.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int CODE_W = 10;
  localparam int OCT_W  = 3;
  localparam int STEP_W = CODE_W - OCT_W;
  localparam int MAG_W  = STEP_W + 2;

  typedef struct packed {
    logic sin_ramps;
    logic ramp_up;
    logic sin_neg;
    logic cos_neg;
  } oct_ctl_t;

  typedef struct packed {
    logic             neg;
    logic [MAG_W-1:0] mag;
  } coil_drv_t;
endpackage

// File: rtl/tcm_octant_decode.sv
module tcm_octant_decode
  import tcm_pkg::*;
#(
  parameter int OW = OCT_W
) (
  input  logic [OW-1:0] octant,
  output oct_ctl_t      ctl
);
  always_comb begin
    ctl.sin_ramps = (octant[0] == octant[1]);
    ctl.ramp_up   = ~octant[0];
    ctl.sin_neg   = octant[2];
    ctl.cos_neg   = octant[2] ^ octant[1];
  end
endmodule

// File: rtl/tcm_ramp_gen.sv
module tcm_ramp_gen #(
  parameter int SW = 7,
  localparam int MW = SW + 2
) (
  input  logic [SW-1:0] step,
  input  logic          rising,
  output logic [MW-1:0] ramp_mag,
  output logic [MW-1:0] full_mag
);
  logic [SW:0] up_v, dn_v;
  always_comb begin
    up_v     = {step, 1'b1};
    dn_v     = ~{step, 1'b0};
    ramp_mag = {1'b0, (rising ? up_v : dn_v)};
    full_mag = MW'(1) << (SW + 1);
  end
endmodule

// File: rtl/tcm_drive_reg.sv
module tcm_drive_reg
  import tcm_pkg::*;
#(
  parameter int MW = MAG_W
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  logic   nxt_sin_neg,
  input  logic [MW-1:0] nxt_sin_mag,
  input  logic   nxt_cos_neg,
  input  logic [MW-1:0] nxt_cos_mag,
  output logic   vld,
  output logic   sin_neg,
  output logic [MW-1:0] sin_mag,
  output logic   cos_neg,
  output logic [MW-1:0] cos_mag
);
  localparam logic [MW-1:0] FULL = MW'(1) << (MW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld     <= 1'b0;
      sin_neg <= 1'b0;
      sin_mag <= MW'(1);
      cos_neg <= 1'b0;
      cos_mag <= FULL;
    end else begin
      vld <= load;
      if (load) begin
        sin_neg <= nxt_sin_neg;
        sin_mag <= nxt_sin_mag;
        cos_neg <= nxt_cos_neg;
        cos_mag <= nxt_cos_mag;
      end
    end
  end
endmodule

// File: rtl/tan_coil_mapper.sv
module tan_coil_mapper
  import tcm_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int OW = OCT_W,
  localparam int SW = CW - OW,
  localparam int MW = SW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_code,
  output logic          out_valid,
  output logic          sin_neg,
  output logic [MW-1:0] sin_mag,
  output logic          cos_neg,
  output logic [MW-1:0] cos_mag
);
  oct_ctl_t      ctl;
  logic [MW-1:0] ramp_mag, full_mag;
  logic [MW-1:0] nxt_sin, nxt_cos;

  assign in_ready = 1'b1;

  tcm_octant_decode #(.OW(OW)) u_dec (
    .octant (in_code[CW-1 -: OW]),
    .ctl    (ctl)
  );

  tcm_ramp_gen #(.SW(SW)) u_ramp (
    .step     (in_code[SW-1:0]),
    .rising   (ctl.ramp_up),
    .ramp_mag (ramp_mag),
    .full_mag (full_mag)
  );

  always_comb begin
    nxt_sin = ctl.sin_ramps ? ramp_mag : full_mag;
    nxt_cos = ctl.sin_ramps ? full_mag : ramp_mag;
  end

  tcm_drive_reg #(.MW(MW)) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (in_valid & in_ready),
    .nxt_sin_neg (ctl.sin_neg),
    .nxt_sin_mag (nxt_sin),
    .nxt_cos_neg (ctl.cos_neg),
    .nxt_cos_mag (nxt_cos),
    .vld         (out_valid),
    .sin_neg     (sin_neg),
    .sin_mag     (sin_mag),
    .cos_neg     (cos_neg),
    .cos_mag     (cos_mag)
  );
endmodule

// File: rtl/tan_coil_mapper_chk.sv
module tan_coil_mapper_chk #(
  parameter int CW = 10,
  parameter int MW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [CW-1:0] in_code,
  input logic          out_valid,
  input logic          sin_neg,
  input logic [MW-1:0] sin_mag,
  input logic          cos_neg,
  input logic [MW-1:0] cos_mag
);
  localparam logic [MW-1:0] FULL = MW'(1) << (MW - 1);

  p_one_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_mag == FULL) != (cos_mag == FULL));

  p_ramp_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_mag == FULL || sin_mag[0]) && (cos_mag == FULL || cos_mag[0]));

  p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (sin_neg == $past(in_code[CW-1])) &&
                 (cos_neg == ($past(in_code[CW-1]) ^ $past(in_code[CW-2]))));

  p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sin_mag) && $stable(cos_mag) &&
                  $stable(sin_neg) && $stable(cos_neg));
endmodule

bind tan_coil_mapper tan_coil_mapper_chk #(.CW(CW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_code(in_code), .out_valid(out_valid), .sin_neg(sin_neg),
  .sin_mag(sin_mag), .cos_neg(cos_neg), .cos_mag(cos_mag)
);

// File: tb/sim_tan_coil_mapper.sv
module sim_tan_coil_mapper;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [9:0] in_code = '0;
  logic in_ready, out_valid, sin_neg, cos_neg;
  logic [8:0] sin_mag, cos_mag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tan_coil_mapper u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_ready(in_ready), .in_code(in_code), .out_valid(out_valid),
    .sin_neg(sin_neg), .sin_mag(sin_mag), .cos_neg(cos_neg), .cos_mag(cos_mag));

  // {code, sin_neg, sin_mag, cos_neg, cos_mag}
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {10'd0,    1'b0, 9'd1,   1'b0, 9'd256},  // R3 R4 oct0 start
    {10'd127,  1'b0, 9'd255, 1'b0, 9'd256},  // R3 oct0 end
    {10'd128,  1'b0, 9'd256, 1'b0, 9'd255},  // R4 oct1
    {10'd197,  1'b0, 9'd256, 1'b0, 9'd117},  // R3 oct1 mid
    {10'd255,  1'b0, 9'd256, 1'b0, 9'd1},
    {10'd256,  1'b0, 9'd256, 1'b1, 9'd1},    // R5 oct2
    {10'd383,  1'b0, 9'd256, 1'b1, 9'd255},
    {10'd384,  1'b0, 9'd255, 1'b1, 9'd256},  // oct3
    {10'd511,  1'b0, 9'd1,   1'b1, 9'd256},
    {10'd512,  1'b1, 9'd1,   1'b1, 9'd256},  // oct4
    {10'd640,  1'b1, 9'd256, 1'b1, 9'd255},  // oct5
    {10'd768,  1'b1, 9'd256, 1'b0, 9'd1},    // oct6
    {10'd896,  1'b1, 9'd255, 1'b0, 9'd256},  // oct7
    {10'd1023, 1'b1, 9'd1,   1'b0, 9'd256}
  };

  task automatic check(string req, logic [19:0] exp);
    logic [19:0] act;
    act = {sin_neg, sin_mag, cos_neg, cos_mag};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R8 reset state
    check("R8 reset drive", {1'b0, 9'd1, 1'b0, 9'd256});
    check1("R8 reset out_valid", out_valid, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check1("R6 in_ready", in_ready, 1'b1);
    // R1 R2 R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      in_code = VEC[i][29:20]; in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      check1("R6 out_valid pulse", out_valid, 1'b1);
      check($sformatf("R1 R2 R3 R4 R5 code %0d", VEC[i][29:20]), VEC[i][19:0]);
      @(negedge clk);
      check1("R6 out_valid drop", out_valid, 1'b0);
    end
    // R7 hold: code changes while in_valid low
    in_code = 10'd300;
    repeat (3) @(negedge clk);
    check("R7 hold", {1'b1, 9'd1, 1'b0, 9'd256});
    // R6 back-to-back accepts
    in_code = 10'd64; in_valid = 1;
    @(negedge clk);
    check("R6 b2b first", {1'b0, 9'd129, 1'b0, 9'd256});
    in_code = 10'd700;  // oct5 n=60 -> cos 135
    @(negedge clk);
    in_valid = 0;
    check("R6 b2b second", {1'b1, 9'd256, 1'b1, 9'd135});
    check1("R6 b2b valid", out_valid, 1'b1);
    // R8 reset mid-run
    rst_n = 0;
    @(negedge clk);
    check("R8 re-reset", {1'b0, 9'd1, 1'b0, 9'd256});
    rst_n = 1;
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule